// File: doc/BRIEF.md
# Four-Layer Cascaded Alpha Compositor

This block composites up to four image layers over a constant background colour on a streaming pixel path. It contains four blend stages in a fixed chain. The first stage uses the background as its destination. Every later stage uses the result of the stage before it. Layer 0 therefore sits at the bottom of the stack and layer 3 at the top.

Each layer has an enable, a premultiplied-alpha flag, a placement offset and a size. Any stage whose layer is disabled passes its destination pixel through unchanged. A stage whose output position lies outside its layer's rectangle does the same.

Upstream presents one beat per output pixel on a valid/ready stream with start-of-frame and end-of-line markers. Each beat carries all four layer words aligned to that output position. Each word holds alpha in bits 31:24 and three colour components in bits 23:16, 15:8 and 7:0. All words share one colour format. The block converts nothing.

Top module: `layer_blend4`

## Requirements
- R1: Layers are applied in a fixed order. Layer 0 blends over the background, and each higher layer blends over the result of all lower layers, so an opaque layer 3 fully determines the output.
- R2: The background colour comes from the low 24 bits of `cfg_bg`. Its alpha is always treated as 0xFF, whatever bits 31:24 hold. As a result every output pixel has alpha 0xFF.
- R3: A straight-alpha layer with alpha a produces colour = rnd(D*(255-a)/255) + rnd(S*a/255) for each component, and alpha = rnd(Da*(255-a)/255) + a. Here rnd rounds to the nearest integer, and each sum saturates at 255.
- R4: A premultiplied layer (its `cfg_premul` bit is 1) produces colour = rnd(D*(255-a)/255) + S, saturating at 255. Its alpha follows the same rule as in R3.
- R5: A layer whose `cfg_en` bit is 0 has no effect on the output, whatever its pixel words hold.
- R6: A layer covers output columns ox to ox+w-1 and rows oy to oy+h-1, where (ox, oy) is its offset and (w, h) its size. Outside that rectangle the layer has no effect. Position (0,0) is the start-of-frame beat, and the column resets after each end-of-line beat.
- R7: Frame width and height are clamped to the range 1 to 8190. A layer offset beyond the last column or row is clamped to that last column or row.
- R8: All configuration inputs are captured with the start-of-frame beat and held for the rest of the frame. Changes made in the middle of a frame take effect only at the next start of frame.
- R9: An accepted beat appears at the output after four clock edges, with its start-of-frame and end-of-line markers. With `out_ready` held high, the block accepts one beat per clock.
- R10: While `out_valid` is high and `out_ready` is low, the output word and markers hold steady. Every accepted beat emerges exactly once, in order.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frame_w | input | 13 | Output frame width |
| cfg_frame_h | input | 13 | Output frame height |
| cfg_bg | input | 32 | Background colour (bits 31:24 ignored) |
| cfg_en | input | 4 | Per-layer enable |
| cfg_premul | input | 4 | Per-layer premultiplied-alpha flag |
| cfg_off_x | input | 52 | Per-layer column offset, 13 bits per layer, layer i at [13i+12:13i] |
| cfg_off_y | input | 52 | Per-layer row offset, same packing |
| cfg_size_w | input | 52 | Per-layer width, same packing |
| cfg_size_h | input | 52 | Per-layer height, same packing |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_eol | input | 1 | Beat is the last pixel of a line |
| in_layers | input | 128 | Four layer words, layer i at [32i+31:32i] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eol | output | 1 | Output end-of-line marker |
| out_pix | output | 32 | Composited pixel |

## Verification
The blend arithmetic is exercised with a set of single-pixel frames whose expected results were worked out by hand. These cover opaque, fully transparent and half-transparent layers, which separate the weighting of the source from the weighting of the destination. One case makes a premultiplied sum overflow, which exposes any missing saturation. Cases with all layers disabled, or with only the top layer enabled, show whether stacking order and pass-through are correct, and a garbage alpha on the background checks that it is forced to 0xFF. Multi-pixel frames with off-centre layer rectangles, clamped offsets, mid-frame configuration changes and a patterned `out_ready` stall probe position tracking, configuration capture and the flow control.

// File: rtl/layer_blend4.sv
module layer_blend4 #(
  parameter int NL     = 4,
  parameter int CW     = 13,
  parameter int MAXDIM = 8190
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_frame_w,
  input  logic [CW-1:0]    cfg_frame_h,
  input  logic [31:0]      cfg_bg,
  input  logic [NL-1:0]    cfg_en,
  input  logic [NL-1:0]    cfg_premul,
  input  logic [NL*CW-1:0] cfg_off_x,
  input  logic [NL*CW-1:0] cfg_off_y,
  input  logic [NL*CW-1:0] cfg_size_w,
  input  logic [NL*CW-1:0] cfg_size_h,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [NL*32-1:0] in_layers,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sof,
  output logic             out_eol,
  output logic [31:0]      out_pix
);
  localparam int PW = 32;
  localparam int LW = NL * PW;
  localparam logic [CW-1:0] DMAX = CW'(MAXDIM);

  function automatic logic [7:0] nrm(input logic [15:0] t);
    logic [16:0] u;
    u = {1'b0, t} + 17'd128;
    return 8'((u + (u >> 8)) >> 8);
  endfunction

  function automatic logic [7:0] sat(input logic [8:0] s);
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] d, input logic [31:0] s, input logic pm);
    logic [7:0] sa, ia, dc, sc, sw;
    logic [31:0] r;
    sa = s[31:24];
    ia = 8'hFF - sa;
    r[31:24] = sat({1'b0, nrm(16'(d[31:24]) * 16'(ia))} + {1'b0, sa});
    for (int k = 0; k < 3; k++) begin
      dc = d[8*k +: 8];
      sc = s[8*k +: 8];
      sw = pm ? sc : nrm(16'(sc) * 16'(sa));
      r[8*k +: 8] = sat({1'b0, nrm(16'(dc) * 16'(ia))} + {1'b0, sw});
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] cdim(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : ((v > DMAX) ? DMAX : v);
  endfunction

  logic adv, take;
  assign adv  = out_ready || !out_valid;
  assign take = in_valid && adv;
  assign in_ready = adv;

  // live (clamped) config and frame-held shadow
  logic [CW-1:0] lv_fw, lv_fh, sh_fw, sh_fh;
  logic [CW-1:0] lv_ox [NL], lv_oy [NL], sh_ox [NL], sh_oy [NL], sh_w [NL], sh_h [NL];
  logic [23:0]   sh_bg;
  logic [NL-1:0] sh_en, sh_pm;
  assign lv_fw = cdim(cfg_frame_w);
  assign lv_fh = cdim(cfg_frame_h);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_fw <= CW'(1); sh_fh <= CW'(1); sh_bg <= '0; sh_en <= '0; sh_pm <= '0;
      for (int i = 0; i < NL; i++) begin
        sh_ox[i] <= '0; sh_oy[i] <= '0; sh_w[i] <= '0; sh_h[i] <= '0;
      end
    end else if (take && in_sof) begin
      sh_fw <= lv_fw; sh_fh <= lv_fh; sh_bg <= cfg_bg[23:0];
      sh_en <= cfg_en; sh_pm <= cfg_premul;
      for (int i = 0; i < NL; i++) begin
        sh_ox[i] <= lv_ox[i]; sh_oy[i] <= lv_oy[i];
        sh_w[i]  <= cfg_size_w[i*CW +: CW]; sh_h[i] <= cfg_size_h[i*CW +: CW];
      end
    end
  end

  // raster position of the beat on the input
  logic [CW-1:0] xc, yc, cur_x, cur_y;
  assign cur_x = in_sof ? '0 : xc;
  assign cur_y = in_sof ? '0 : yc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xc <= '0; yc <= '0;
    end else if (take) begin
      xc <= in_eol ? '0 : cur_x + CW'(1);
      yc <= in_eol ? cur_y + CW'(1) : cur_y;
    end
  end

  logic [NL-1:0] cov;
  for (genvar g = 0; g < NL; g++) begin : g_cov
    logic [CW-1:0] ox, oy, lw, lh;
    logic [CW:0]   xe, ye;
    assign lv_ox[g] = (cfg_off_x[g*CW +: CW] > lv_fw - CW'(1)) ? lv_fw - CW'(1) : cfg_off_x[g*CW +: CW];
    assign lv_oy[g] = (cfg_off_y[g*CW +: CW] > lv_fh - CW'(1)) ? lv_fh - CW'(1) : cfg_off_y[g*CW +: CW];
    assign ox = in_sof ? lv_ox[g] : sh_ox[g];
    assign oy = in_sof ? lv_oy[g] : sh_oy[g];
    assign lw = in_sof ? cfg_size_w[g*CW +: CW] : sh_w[g];
    assign lh = in_sof ? cfg_size_h[g*CW +: CW] : sh_h[g];
    assign xe = {1'b0, ox} + {1'b0, lw};
    assign ye = {1'b0, oy} + {1'b0, lh};
    assign cov[g] = (in_sof ? cfg_en[g] : sh_en[g]) &&
                    cur_x >= ox && {1'b0, cur_x} < xe &&
                    cur_y >= oy && {1'b0, cur_y} < ye;
  end

  // blend chain: one register per stage
  logic          pv  [NL];
  logic          psof[NL], peol[NL];
  logic [31:0]   ppx [NL];
  logic [NL-1:0] pact[NL], ppm[NL];
  logic [LW-1:0] ply [NL];

  for (genvar g = 0; g < NL; g++) begin : g_stage
    logic          iv, isof, ieol;
    logic [31:0]   ipx;
    logic [NL-1:0] iact, ipm;
    logic [LW-1:0] ily;
    if (g == 0) begin : g_head
      assign iv = in_valid; assign isof = in_sof; assign ieol = in_eol;
      assign ipx  = {8'hFF, in_sof ? cfg_bg[23:0] : sh_bg};
      assign iact = cov;
      assign ipm  = in_sof ? cfg_premul : sh_pm;
      assign ily  = in_layers;
    end else begin : g_link
      assign iv = pv[g-1]; assign isof = psof[g-1]; assign ieol = peol[g-1];
      assign ipx = ppx[g-1]; assign iact = pact[g-1]; assign ipm = ppm[g-1]; assign ily = ply[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv[g] <= 1'b0; psof[g] <= 1'b0; peol[g] <= 1'b0;
        ppx[g] <= '0; pact[g] <= '0; ppm[g] <= '0; ply[g] <= '0;
      end else if (adv) begin
        pv[g] <= iv; psof[g] <= isof; peol[g] <= ieol;
        ppx[g] <= iact[g] ? mix(ipx, ily[g*PW +: PW], ipm[g]) : ipx;
        pact[g] <= iact; ppm[g] <= ipm; ply[g] <= ily;
      end
    end
  end

  assign out_valid = pv[NL-1];
  assign out_sof   = psof[NL-1];
  assign out_eol   = peol[NL-1];
  assign out_pix   = ppx[NL-1];

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol));

  // R2
  opaque_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pix[31:24] == 8'hFF);

  // R8
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && in_sof) |=> $stable(sh_en) && $stable(sh_pm) && $stable(sh_bg));

  for (genvar g = 0; g < NL; g++) begin : g_chk
    // R7
    off_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_ox[g] < sh_fw && sh_oy[g] < sh_fh && sh_fw <= DMAX && sh_fh != '0);
  end
endmodule

// File: tb/layer_blend4_test.sv
module layer_blend4_test;
  localparam int CW = 13;

  typedef struct packed {
    logic [3:0]  en;
    logic [3:0]  pm;
    logic [23:0] bg;
    logic [31:0] l0, l1, l2, l3;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VT [10] = '{
    '{4'b0000, 4'b0000, 24'h102030, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFF102030},
    '{4'b0001, 4'b0000, 24'h000000, 32'hFFAABBCC, 32'h0,        32'h0,        32'h0,        32'hFFAABBCC},
    '{4'b1111, 4'b0000, 24'h000000, 32'hFF010101, 32'hFF020202, 32'hFF030303, 32'hFF112233, 32'hFF112233},
    '{4'b0001, 4'b0000, 24'h405060, 32'h00FFFFFF, 32'h0,        32'h0,        32'h0,        32'hFF405060},
    '{4'b0001, 4'b0000, 24'h000000, 32'h80FF0000, 32'h0,        32'h0,        32'h0,        32'hFF800000},
    '{4'b0001, 4'b0001, 24'h000000, 32'h80400000, 32'h0,        32'h0,        32'h0,        32'hFF400000},
    '{4'b0001, 4'b0001, 24'hFF0000, 32'h80FF0000, 32'h0,        32'h0,        32'h0,        32'hFFFF0000},
    '{4'b0001, 4'b0000, 24'h646464, 32'h40C8C8C8, 32'h0,        32'h0,        32'h0,        32'hFF7D7D7D},
    '{4'b1000, 4'b0000, 24'h000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h800000FF, 32'hFF000080},
    '{4'b0011, 4'b0000, 24'h000000, 32'hFF00FF00, 32'h80FF0000, 32'h0,        32'h0,        32'hFF807F00}
  };
  localparam string VTAG [10] = '{"R5", "R3", "R1", "R3", "R3", "R4", "R4", "R3", "R5", "R1"};

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cfg_frame_w = 1, cfg_frame_h = 1;
  logic [31:0] cfg_bg = 0;
  logic [3:0] cfg_en = 0, cfg_premul = 0;
  logic [4*CW-1:0] cfg_off_x = 0, cfg_off_y = 0, cfg_size_w = 0, cfg_size_h = 0;
  logic in_valid = 0, in_sof = 0, in_eol = 0, out_ready = 1;
  logic [127:0] in_layers = 0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [31:0] out_pix;

  int checks = 0, fails = 0, cyc = 0;
  bit stall_en = 0, done = 0;
  logic [33:0] exp_q [$];
  string tag_q [$];
  logic pstall = 0;
  logic [33:0] pout = 0;

  always #5 clk = ~clk;

  layer_blend4 uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pstall) chk(out_valid && {out_sof, out_eol, out_pix} == pout, "R10 hold", {out_valid, out_sof, out_eol, out_pix[30:0]}, pout);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R10 extra beat", {out_sof, out_eol, out_pix}, 0);
        else begin
          logic [33:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk({out_sof, out_eol, out_pix} == e, t, {out_sof, out_eol, out_pix}, e);
        end
      end
      pstall = out_valid && !out_ready;
      pout = {out_sof, out_eol, out_pix};
    end
  end

  task automatic beat(input logic [127:0] ly, input logic s, input logic e, input logic [31:0] ex, input string tag);
    in_layers = ly; in_sof = s; in_eol = e; in_valid = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back({s, e, ex}); tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R10 lost beat", 34'(exp_q.size()), 0);
    @(posedge clk); #1;
  endtask

  task automatic run_table();
    for (int i = 0; i < 10; i++) begin
      cfg_frame_w = 1; cfg_frame_h = 1;
      cfg_bg = {8'h00, VT[i].bg};
      cfg_en = VT[i].en; cfg_premul = VT[i].pm;
      cfg_off_x = 0; cfg_off_y = 0;
      cfg_size_w = {4{13'd1}}; cfg_size_h = {4{13'd1}};
      beat({VT[i].l3, VT[i].l2, VT[i].l1, VT[i].l0}, 1'b1, 1'b1, VT[i].ex, VTAG[i]);
    end
  endtask

  localparam logic [31:0] LP = 32'hFFAABBCC;
  localparam logic [31:0] BG = 32'hFF000000;

  initial begin
    #1;
    // R11 reset state
    chk(out_valid == 0 && in_ready == 1, "R11", {out_valid, in_ready}, 34'b01);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(out_valid == 0 && in_ready == 1, "R11", {out_valid, in_ready}, 34'b01);
    @(posedge clk); #1;

    // R1 R2 R3 R4 R5 table, no stall
    run_table();
    drain();

    // R9 latency
    cfg_en = 4'b0001; cfg_premul = 0; cfg_bg = 0;
    in_layers = {96'h0, LP}; in_sof = 1; in_eol = 1; in_valid = 1;
    exp_q.push_back({2'b11, LP}); tag_q.push_back("R9 data");
    @(posedge clk); #1 in_valid = 0;
    @(posedge clk); @(posedge clk); #1;
    chk(out_valid == 0, "R9 early", 34'(out_valid), 0);
    @(posedge clk); #1;
    chk(out_valid == 1 && out_sof && out_eol, "R9 on time", {out_valid, out_sof, out_eol}, 34'b111);
    drain();

    // R6 placed rectangle: frame 4x2, layer0 at (1,0) size 2x1
    cfg_frame_w = 4; cfg_frame_h = 2; cfg_bg = 0; cfg_en = 4'b0001; cfg_premul = 0;
    cfg_off_x = 52'd1; cfg_off_y = 0; cfg_size_w = 52'd2; cfg_size_h = 52'd1;
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 4; x++)
        beat({96'h0, LP}, x == 0 && y == 0, x == 3, (y == 0 && (x == 1 || x == 2)) ? LP : BG, "R6");
    drain();

    // R7 frame width 0 clamps to 1, offset 5 clamps to column 0
    cfg_frame_w = 0; cfg_frame_h = 1; cfg_off_x = 52'd5; cfg_size_w = 52'd1; cfg_size_h = 52'd1;
    beat({96'h0, LP}, 1, 1, LP, "R7 zero width");
    // R7 frame 3x1, offset 10 clamps to column 2
    cfg_frame_w = 3; cfg_off_x = 52'd10; cfg_size_w = 52'd5;
    for (int x = 0; x < 3; x++) beat({96'h0, LP}, x == 0, x == 2, x == 2 ? LP : BG, "R7 clamp");
    drain();

    // R8 mid-frame change ignored, applied next frame
    cfg_frame_w = 2; cfg_off_x = 0; cfg_size_w = 52'd2; cfg_en = 4'b0001;
    beat({96'h0, LP}, 1, 0, LP, "R8");
    cfg_en = 4'b0000; cfg_bg = 32'h00123456;
    beat({96'h0, LP}, 0, 1, LP, "R8 held");
    beat({96'h0, LP}, 1, 1, 32'hFF123456, "R8 next frame");
    drain();

    // R10 back-pressure: table streamed with patterned out_ready
    stall_en = 1;
    run_table();
    drain();
    stall_en = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule